// File: doc/BRIEF.md
# Port Falling-Edge Interrupt and Wake Controller

This block watches a group of general-purpose input pins for high-to-low transitions. Every pin passes through a synchroniser, and a falling edge on pin n latches a sticky flag in bit n of an 8-bit flag register. Software reads that register, and writes it back to clear bits. A single enable input decides whether any pending flag raises the interrupt request toward the CPU.

A second output, the wake request, does not depend on the enable. While the CPU reports a halt or stop state on the sleep input, any new falling edge produces a one-cycle wake pulse. The CPU then resumes, either straight into the interrupt service (enable set) or just at the next instruction (enable clear). A pin whose direction control marks it as an output is excluded from detection altogether.

Top module: `pin_fall_wake`

## Requirements
- R1: After reset the flag register reads 0x00 and both irqReq and wakeReq are 0.
- R2: A high-to-low change on input pin n (dirOut[n]=0) sets flag bit n. The change is visible on regRdData at the third rising clock edge after the pin changes: two synchroniser stages plus one detection register.
- R3: A low-to-high change on a pin sets no flag.
- R4: A falling edge on a pin whose dirOut bit is 1 sets no flag and produces no wake pulse.
- R5: Bit 7 of regRdData always reads 0, even after writing 1 to it.
- R6: A write (regWrEn=1 for one cycle) replaces flag bits 6..0 with regWrData[6:0]. Writing 0 to a bit clears it, and writing 1 to a bit sets it.
- R7: If a falling edge on pin n and a software write of 0 to bit n take effect at the same clock edge, bit n ends up set.
- R8: irqReq is 1 exactly while irqEnable is 1 and at least one flag bit is set.
- R9: While sleepActive is 1, a detected falling edge gives wakeReq=1 for exactly one cycle, with irqEnable either 0 or 1. This happens at the same edge that sets the flag.
- R10: While sleepActive is 0, falling edges give no wake pulse.
- R11: Falling edges on several pins in the same cycle set all of the corresponding flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 7 | Raw, asynchronous pin levels |
| dirOut | input | 7 | Per-pin direction, 1 = output (excluded) |
| irqEnable | input | 1 | Global interrupt enable |
| sleepActive | input | 1 | CPU is in halt or stop state |
| regWrEn | input | 1 | Write strobe for the flag register |
| regWrData | input | 8 | Write data for the flag register |
| regRdData | output | 8 | Flag register contents, bit 7 = 0 |
| irqReq | output | 1 | Interrupt request (level) |
| wakeReq | output | 1 | Wake request (one-cycle pulse) |

## Verification
The assertions assume that reset is applied before the first clock edge. They also assume that a write strobe lasts one cycle and that regWrData is valid whenever regWrEn is high. No assumption is placed on pin timing, because the synchroniser absorbs it. The stimulus changes pins, strobes and control inputs only on falling clock edges. It leaves several idle cycles between scenarios so that every edge has passed through the synchroniser before the next check.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  // Width of the software-visible flag register
  localparam int REG_W = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic flagWrite;   // load flag bits from write data this cycle
    logic edgeCapture; // let detected edges set flags this cycle
  } pfw_strobes_t;
endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageReg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageReg[s] <= '0;
    end else begin
      stageReg[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageReg[s] <= stageReg[s-1];
    end
  end

  assign syncOut = stageReg[STAGES-1];
endmodule

// File: rtl/pfw_datapath.sv
module pfw_datapath
  import pfw_pkg::*;
#(
  parameter int NUM_PINS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] dirOut,
  input  logic [REG_W-1:0]    wrData,
  input  pfw_strobes_t        strobes,
  output logic [NUM_PINS-1:0] edgeVec,
  output logic [NUM_PINS-1:0] flags
);
  logic [NUM_PINS-1:0] syncLvl;
  logic [NUM_PINS-1:0] prevLvl;
  logic [NUM_PINS-1:0] flagsNext;
  logic [NUM_PINS-1:0] wrBits;

  pfw_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinIn),
    .syncOut(syncLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= syncLvl;
  end

  // Falling edge per pin, only for pins in input mode
  for (genvar p = 0; p < NUM_PINS; p++) begin : gEdge
    assign edgeVec[p] = prevLvl[p] & ~syncLvl[p] & ~dirOut[p];
  end

  assign wrBits = wrData[NUM_PINS-1:0];

  // Hardware set is ORed after the software load, so it wins a collision
  always_comb begin
    flagsNext = strobes.flagWrite ? wrBits : flags;
    if (strobes.edgeCapture) flagsNext = flagsNext | edgeVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsNext;
  end

  // R2 R7 R11
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeVec) |=> ((flags & $past(edgeVec)) == $past(edgeVec)));

  // R3 R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.flagWrite && edgeVec == '0) |=> $stable(flags));

  // R4
  out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeVec & dirOut) == '0));
endmodule

// File: rtl/pfw_control.sv
module pfw_control
  import pfw_pkg::*;
#(
  parameter int NUM_PINS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                irqEnable,
  input  logic                sleepActive,
  input  logic [NUM_PINS-1:0] edgeVec,
  input  logic [NUM_PINS-1:0] flags,
  output pfw_strobes_t        strobes,
  output logic                irqReq,
  output logic                wakeReq
);
  logic anyEdge;
  logic wakeReg;

  assign anyEdge = |edgeVec;

  always_comb begin
    strobes.flagWrite   = regWrEn;
    strobes.edgeCapture = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeReg <= 1'b0;
    else       wakeReg <= sleepActive & anyEdge;
  end

  assign wakeReq = wakeReg;
  assign irqReq  = irqEnable & (|flags);

  // R9
  wake_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepActive && anyEdge) |=> wakeReq);

  // R10
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(sleepActive));

  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqReq);
endmodule

// File: rtl/pin_fall_wake.sv
module pin_fall_wake
  import pfw_pkg::*;
#(
  parameter int NUM_PINS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] dirOut,
  input  logic                irqEnable,
  input  logic                sleepActive,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic                irqReq,
  output logic                wakeReq
);
  pfw_strobes_t        strobes;
  logic [NUM_PINS-1:0] edgeVec;
  logic [NUM_PINS-1:0] flags;

  pfw_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .dirOut (dirOut),
    .wrData (regWrData),
    .strobes(strobes),
    .edgeVec(edgeVec),
    .flags  (flags)
  );

  pfw_control #(.NUM_PINS(NUM_PINS)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .irqEnable  (irqEnable),
    .sleepActive(sleepActive),
    .edgeVec    (edgeVec),
    .flags      (flags),
    .strobes    (strobes),
    .irqReq     (irqReq),
    .wakeReq    (wakeReq)
  );

  // Unused upper bits read as zero
  assign regRdData = REG_W'(flags);

  // R5
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData[REG_W-1] == 1'b0));
endmodule

// File: tb/tb_pin_fall_wake.sv
module tb_pin_fall_wake;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] pinIn = 7'h7F;
  logic [6:0] dirOut = '0;
  logic       irqEnable = 1'b0;
  logic       sleepActive = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqReq;
  logic       wakeReq;

  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_fall_wake dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .dirOut(dirOut),
    .irqEnable(irqEnable), .sleepActive(sleepActive),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq), .wakeReq(wakeReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeFlags(input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Drop the masked pins at a negedge, then stop at the negedge after the 3rd posedge
  task automatic dropPins(input logic [6:0] m);
    @(negedge clk);
    pinIn = pinIn & ~m;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic raiseAll();
    @(negedge clk);
    pinIn = 7'h7F;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check(regRdData == 8'h00, "R1 flags", regRdData, 0);
    check(irqReq == 1'b0, "R1 irq", irqReq, 0);
    check(wakeReq == 1'b0, "R1 wake", wakeReq, 0);
  endtask

  task automatic testSingleEdge();
    writeFlags(8'h00);
    dropPins(7'h08);
    check(regRdData == 8'h08, "R2 flag3", regRdData, 8'h08);
    raiseAll();
    check(regRdData == 8'h08, "R3 rise no set", regRdData, 8'h08);
    writeFlags(8'h00);
    check(regRdData == 8'h00, "R6 clear", regRdData, 0);
  endtask

  task automatic testLatency();
    writeFlags(8'h00);
    @(negedge clk);
    pinIn[0] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(regRdData == 8'h00, "R2 not before 3rd edge", regRdData, 0);
    @(posedge clk);
    @(negedge clk);
    check(regRdData == 8'h01, "R2 at 3rd edge", regRdData, 1);
    raiseAll();
    writeFlags(8'h00);
  endtask

  task automatic testOutputPin();
    writeFlags(8'h00);
    dirOut = 7'h20;
    sleepActive = 1'b1;
    dropPins(7'h20);
    check(regRdData == 8'h00, "R4 out pin flag", regRdData, 0);
    check(wakeReq == 1'b0, "R4 out pin wake", wakeReq, 0);
    sleepActive = 1'b0;
    raiseAll();
    dirOut = '0;
  endtask

  task automatic testTopBit();
    writeFlags(8'hFF);
    check(regRdData == 8'h7F, "R5 bit7 zero, R6 set", regRdData, 8'h7F);
    writeFlags(8'h00);
  endtask

  task automatic testCollision();
    writeFlags(8'h00);
    writeFlags(8'h04);
    @(negedge clk);
    pinIn[2] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = 8'h00;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    check(regRdData == 8'h04, "R7 set wins", regRdData, 8'h04);
    raiseAll();
    writeFlags(8'h00);
  endtask

  task automatic testIrq();
    writeFlags(8'h00);
    irqEnable = 1'b0;
    dropPins(7'h02);
    check(irqReq == 1'b0, "R8 disabled", irqReq, 0);
    irqEnable = 1'b1;
    #1;
    check(irqReq == 1'b1, "R8 enabled", irqReq, 1);
    writeFlags(8'h00);
    check(irqReq == 1'b0, "R8 after clear", irqReq, 0);
    irqEnable = 1'b0;
    raiseAll();
  endtask

  task automatic testWake(input logic en);
    writeFlags(8'h00);
    irqEnable = en;
    sleepActive = 1'b1;
    dropPins(7'h40);
    check(wakeReq == 1'b1, en ? "R9 wake en=1" : "R9 wake en=0", wakeReq, 1);
    @(negedge clk);
    check(wakeReq == 1'b0, "R9 one cycle", wakeReq, 0);
    sleepActive = 1'b0;
    irqEnable = 1'b0;
    raiseAll();
    writeFlags(8'h00);
  endtask

  task automatic testNoWakeAwake();
    writeFlags(8'h00);
    sleepActive = 1'b0;
    @(negedge clk);
    pinIn[4] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(wakeReq == 1'b0, "R10 awake no wake", wakeReq, 0);
    end
    raiseAll();
    writeFlags(8'h00);
  endtask

  task automatic testMulti();
    writeFlags(8'h00);
    dropPins(7'h55);
    check(regRdData == 8'h55, "R11 multi", regRdData, 8'h55);
    raiseAll();
    writeFlags(8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCnt++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testSingleEdge();
    testLatency();
    testOutputPin();
    testTopBit();
    testCollision();
    testIrq();
    testWake(1'b0);
    testWake(1'b1);
    testNoWakeAwake();
    testMulti();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule